// File: doc/BRIEF.md
# Trigger Edge Interrupt Vector Generator

This block watches up to eight external trigger pins and one internal event strobe. It turns each detected level change into a numbered interrupt vector request for a small sequencer core. Each pin first passes through a multi-flop synchroniser. The synchronised level is then compared with its value one cycle earlier. Each pin has two vectors: one for a change to high and one for a change to low.

Pins are handled in groups of four. Within each group of eight vectors, the four high-to-low vectors come first and the four low-to-high vectors follow. The first group holds vectors 0 to 7 and the second holds vectors 8 to 15. The internal event has vector 32. Every vector has a pending bit that holds the request until the core takes it. The lowest-numbered pending vector is offered first. Once a vector is offered, it stays on the output until the core acknowledges it. The parameter `NUM_TRIG` sets how many pins are active. Pin slots above that count are not connected to any logic.

Top module: `trig_vec_gen`

## Requirements
- R1: While `rst_n` is low, and after its release, `req_o` is 0 and `vec_o` is 0. A pin held high across reset release raises no vector.
- R2: A high-to-low change on pin p, with p from 0 to 3, raises vector p.
- R3: A low-to-high change on pin p, with p from 0 to 3, raises vector 4+p.
- R4: On pins p from 4 to 7, a high-to-low change raises vector 8+(p-4) and a low-to-high change raises vector 12+(p-4).
- R5: A cycle with `evt_i` high raises vector 32. The only vectors that can appear are 0 to 15 and 32.
- R6: With `NUM_TRIG` = 4, changes on pins 4 to 7 raise nothing, so only vectors 0 to 7 and 32 can appear.
- R7: A pin change driven before clock edge k is offered on `req_o`/`vec_o` after edge k+2. An `evt_i` pulse sampled at edge k is offered after edge k.
- R8: When several vectors are pending and none is being held, the lowest number is offered first. Vector 32 is therefore offered after all pending pin vectors.
- R9: While `req_o` is 1 and `ack_i` is 0, `vec_o` does not change on the next cycle. A lower vector that arrives later does not displace it.
- R10: `ack_i` high at a clock edge where `req_o` is 1 clears the pending bit of the vector on `vec_o`. With `req_o` at 0, `ack_i` has no effect.
- R11: A repeat change on a pin whose vector is still pending is absorbed. One acknowledge removes that vector.
- R12: `req_o` is 1 exactly when some vector is pending. While `req_o` is 0, `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | TRIG_SLOTS (8) | Trigger pin levels, asynchronous to clk |
| evt_i | input | 1 | Internal event strobe, synchronous to clk |
| ack_i | input | 1 | Core takes the vector now on vec_o |
| req_o | output | 1 | A vector is pending |
| vec_o | output | VEC_W (6) | Vector number being offered |

## Verification
A pin change reaches the outputs three clock edges after it is driven: two edges in the synchroniser and one into the pending bit. After two edges the bench confirms that `req_o` is still low, and after the third it checks the vector. An `evt_i` pulse and an acknowledge each act on the very next edge, so the bench samples on the falling edge that follows. The bench drives every input on a falling clock edge. Priority, hold and absorption cases are staged so that several requests land on the same rising edge, or so that a lower vector arrives while another is held.

// File: rtl/tvg_pkg.sv
package tvg_pkg;

   // pins are handled in groups of this size; vector numbering depends on it
   localparam int unsigned GRP = 4;

   // pending slot for a pin change; slot number equals vector number
   function automatic int unsigned slot_of(input int unsigned pin, input bit rise);
      return (pin / GRP) * (2 * GRP) + (rise ? GRP : 0) + (pin % GRP);
   endfunction

   // highest trigger vector number + 1 for a given active pin count
   function automatic int unsigned trig_vec_limit(input int unsigned npins);
      return ((npins + GRP - 1) / GRP) * (2 * GRP);
   endfunction

endpackage

// File: rtl/tvg_sync.sv
module tvg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[STAGES-2:0], d_i};
   end

   assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tvg_edge.sv
module tvg_edge #(
   parameter int unsigned N      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   // the sync chain plus the history flop must be filled before edges count
   localparam int unsigned PRIME = STAGES + 1;
   localparam int unsigned CW    = $clog2(PRIME + 1);

   logic [N-1:0]  prev_q;
   logic [CW-1:0] prime_q;
   logic          armed;

   assign armed = (prime_q == CW'(PRIME));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         prime_q <= '0;
      end else begin
         prev_q <= lvl_i;
         if (!armed) prime_q <= prime_q + CW'(1);
      end
   end

   assign rise_o = armed ? ( lvl_i & ~prev_q) : '0;
   assign fall_o = armed ? (~lvl_i &  prev_q) : '0;
endmodule

// File: rtl/tvg_pend.sv
module tvg_pend #(
   parameter int unsigned SLOTS = 8,
   parameter int unsigned NPEND = 2 * SLOTS + 1,
   parameter int unsigned IDX_W = $clog2(NPEND)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] rise_i,
   input  logic [SLOTS-1:0] fall_i,
   input  logic             evt_i,
   input  logic             clr_i,
   input  logic [IDX_W-1:0] clr_idx_i,
   output logic [NPEND-1:0] pend_o
);
   import tvg_pkg::*;

   logic [NPEND-1:0] set_m;
   logic [NPEND-1:0] clr_m;
   logic [NPEND-1:0] pend_q;

   for (genvar p = 0; p < SLOTS; p++) begin : g_map
      localparam int unsigned FS = slot_of(p, 1'b0);
      localparam int unsigned RS = slot_of(p, 1'b1);
      assign set_m[FS] = fall_i[p];
      assign set_m[RS] = rise_i[p];
   end
   assign set_m[NPEND-1] = evt_i;

   always_comb begin
      clr_m = '0;
      if (clr_i) clr_m[clr_idx_i] = 1'b1;
   end

   // a new detection in the same cycle as its clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_m) | set_m;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/tvg_arb.sv
module tvg_arb #(
   parameter int unsigned NPEND = 17,
   parameter int unsigned IDX_W = $clog2(NPEND)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPEND-1:0] pend_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic [IDX_W-1:0] sel_o,
   output logic             take_o
);
   logic [IDX_W-1:0] low_idx;
   logic             hold_q;
   logic [IDX_W-1:0] hold_idx_q;

   always_comb begin
      low_idx = '0;
      for (int i = NPEND - 1; i >= 0; i--) begin
         if (pend_i[i]) low_idx = IDX_W'(i);
      end
   end

   assign req_o  = |pend_i;
   assign sel_o  = hold_q ? hold_idx_q : low_idx;
   assign take_o = req_o && ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= 1'b0;
         hold_idx_q <= '0;
      end else if (take_o) begin
         hold_q <= 1'b0;
      end else if (req_o) begin
         hold_q     <= 1'b1;
         hold_idx_q <= sel_o;
      end
   end
endmodule

// File: rtl/trig_vec_gen.sv
module trig_vec_gen #(
   parameter int unsigned TRIG_SLOTS  = 8,
   parameter int unsigned NUM_TRIG    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned VEC_W       = 6,
   parameter int unsigned EVT_VEC     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [TRIG_SLOTS-1:0] trig_i,
   input  logic                  evt_i,
   input  logic                  ack_i,
   output logic                  req_o,
   output logic [VEC_W-1:0]      vec_o
);
   import tvg_pkg::*;

   localparam int unsigned NPEND = 2 * TRIG_SLOTS + 1;
   localparam int unsigned IDX_W = $clog2(NPEND);

   if (TRIG_SLOTS % GRP != 0 || TRIG_SLOTS == 0) begin : g_bad_slots
      $error("TRIG_SLOTS must be a nonzero multiple of the group size");
   end
   if (NUM_TRIG == 0 || NUM_TRIG > TRIG_SLOTS) begin : g_bad_num
      $error("NUM_TRIG must be in 1..TRIG_SLOTS");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (EVT_VEC < 2 * TRIG_SLOTS || EVT_VEC >= (1 << VEC_W) || IDX_W > VEC_W) begin : g_bad_vec
      $error("EVT_VEC or VEC_W out of range");
   end

   logic [TRIG_SLOTS-1:0] lvl;
   logic [TRIG_SLOTS-1:0] rise;
   logic [TRIG_SLOTS-1:0] fall;
   logic [NPEND-1:0]      pend;
   logic [IDX_W-1:0]      sel;
   logic                  take;

   for (genvar p = 0; p < TRIG_SLOTS; p++) begin : g_pin
      if (p < NUM_TRIG) begin : g_live
         tvg_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (trig_i[p]),
            .q_o   (lvl[p])
         );
      end else begin : g_dead
         assign lvl[p] = 1'b0;
      end
   end

   tvg_edge #(.N(TRIG_SLOTS), .STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .rise_o (rise),
      .fall_o (fall)
   );

   tvg_pend #(.SLOTS(TRIG_SLOTS), .NPEND(NPEND), .IDX_W(IDX_W)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise),
      .fall_i    (fall),
      .evt_i     (evt_i),
      .clr_i     (take),
      .clr_idx_i (sel),
      .pend_o    (pend)
   );

   tvg_arb #(.NPEND(NPEND), .IDX_W(IDX_W)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .ack_i  (ack_i),
      .req_o  (req_o),
      .sel_o  (sel),
      .take_o (take)
   );

   always_comb begin
      if (!req_o)                         vec_o = '0;
      else if (sel == IDX_W'(NPEND - 1))  vec_o = VEC_W'(EVT_VEC);
      else                                vec_o = VEC_W'(sel);
   end
endmodule

// File: rtl/tvg_chk.sv
module tvg_chk #(
   parameter int unsigned NUM_TRIG = 8,
   parameter int unsigned VEC_W    = 6,
   parameter int unsigned EVT_VEC  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack_i,
   input logic             req_o,
   input logic [VEC_W-1:0] vec_o
);
   import tvg_pkg::*;
   localparam int unsigned LIM = trig_vec_limit(NUM_TRIG);

   // R9: offered vector is held until acknowledged
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> (req_o && $stable(vec_o)));

   // R12: idle output is zero
   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !req_o |-> (vec_o == '0));

   // R5: only trigger vectors 0..15 or the event vector appear
   a_r5_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> ((int'(vec_o) < 16) || (int'(vec_o) == EVT_VEC)));

   // R6: vectors stay within the range the active pin count allows
   a_r6_cfg_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> ((int'(vec_o) < LIM) || (int'(vec_o) == EVT_VEC)));
endmodule

bind trig_vec_gen tvg_chk #(
   .NUM_TRIG (NUM_TRIG),
   .VEC_W    (VEC_W),
   .EVT_VEC  (EVT_VEC)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ack_i (ack_i),
   .req_o (req_o),
   .vec_o (vec_o)
);

// File: tb/trig_vec_gen_tb.sv
module trig_vec_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] trig = 8'h04;
   logic       evt = 1'b0;
   logic       ack = 1'b0;
   logic       req;
   logic [5:0] vec;
   logic [7:0] trig4 = 8'h00;
   logic       evt4 = 1'b0;
   logic       ack4 = 1'b0;
   logic       req4;
   logic [5:0] vec4;
   int         total = 0;
   int         bad = 0;

   always #5 clk = ~clk;

   trig_vec_gen u_dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .evt_i(evt), .ack_i(ack),
      .req_o(req), .vec_o(vec)
   );

   trig_vec_gen #(.NUM_TRIG(4)) u_dut4 (
      .clk(clk), .rst_n(rst_n), .trig_i(trig4), .evt_i(evt4), .ack_i(ack4),
      .req_o(req4), .vec_o(vec4)
   );

   task automatic chk(input string tag, input logic r, input logic [5:0] v,
                      input logic er, input logic [5:0] ev);
      total++;
      if (r !== er || v !== ev) begin
         bad++;
         $display("FAIL %s: req=%0b vec=%0d expected req=%0b vec=%0d", tag, r, v, er, ev);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_ack;
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic t_reset;
      wait_n(3);
      chk("R1 in reset", req, vec, 1'b0, 6'd0);
      rst_n = 1'b1;
      wait_n(8);
      chk("R1 high pin across reset", req, vec, 1'b0, 6'd0);
   endtask

   task automatic t_fall_low;
      trig[2] = 1'b0;
      wait_n(2);
      chk("R7 not yet after two edges", req, vec, 1'b0, 6'd0);
      wait_n(1);
      chk("R2 pin2 fall", req, vec, 1'b1, 6'd2);
      do_ack();
      chk("R10 ack clears", req, vec, 1'b0, 6'd0);
   endtask

   task automatic t_rise_low;
      trig[1] = 1'b1;
      wait_n(3);
      chk("R3 pin1 rise", req, vec, 1'b1, 6'd5);
      do_ack();
      chk("R12 idle after ack", req, vec, 1'b0, 6'd0);
   endtask

   task automatic t_high_group;
      trig[6] = 1'b1;
      wait_n(3);
      chk("R4 pin6 rise", req, vec, 1'b1, 6'd14);
      do_ack();
      trig[6] = 1'b0;
      trig[4] = 1'b1;
      wait_n(3);
      chk("R4 pin6 fall first", req, vec, 1'b1, 6'd10);
      do_ack();
      chk("R4 pin4 rise", req, vec, 1'b1, 6'd12);
      do_ack();
      chk("R4 idle", req, vec, 1'b0, 6'd0);
   endtask

   task automatic t_event;
      evt = 1'b1;
      @(negedge clk);
      evt = 1'b0;
      chk("R5 R7 event one edge", req, vec, 1'b1, 6'd32);
      do_ack();
      chk("R5 event cleared", req, vec, 1'b0, 6'd0);
   endtask

   task automatic t_priority;
      trig[0] = 1'b1;
      trig[7] = 1'b1;
      wait_n(2);
      evt = 1'b1;
      wait_n(1);
      evt = 1'b0;
      chk("R8 lowest first", req, vec, 1'b1, 6'd4);
      do_ack();
      chk("R8 next", req, vec, 1'b1, 6'd15);
      do_ack();
      chk("R8 event last", req, vec, 1'b1, 6'd32);
      do_ack();
      chk("R8 idle", req, vec, 1'b0, 6'd0);
   endtask

   task automatic t_hold;
      trig[5] = 1'b1;
      wait_n(3);
      chk("R9 first offered", req, vec, 1'b1, 6'd13);
      trig[3] = 1'b1;
      wait_n(4);
      chk("R9 held against lower", req, vec, 1'b1, 6'd13);
      do_ack();
      chk("R9 lower after ack", req, vec, 1'b1, 6'd7);
      do_ack();
      chk("R9 idle", req, vec, 1'b0, 6'd0);
   endtask

   task automatic t_ack_idle;
      do_ack();
      chk("R10 ack while idle", req, vec, 1'b0, 6'd0);
      trig[0] = 1'b0;
      wait_n(3);
      chk("R10 later vector intact", req, vec, 1'b1, 6'd0);
      do_ack();
      chk("R10 cleared", req, vec, 1'b0, 6'd0);
   endtask

   task automatic t_absorb;
      trig[2] = 1'b1;
      wait_n(4);
      trig[2] = 1'b0;
      wait_n(4);
      trig[2] = 1'b1;
      wait_n(4);
      chk("R11 held first", req, vec, 1'b1, 6'd6);
      do_ack();
      chk("R11 second", req, vec, 1'b1, 6'd2);
      do_ack();
      chk("R11 repeat absorbed", req, vec, 1'b0, 6'd0);
   endtask

   task automatic t_small;
      trig4[5] = 1'b1;
      trig4[7] = 1'b1;
      wait_n(5);
      chk("R6 upper pins ignored", req4, vec4, 1'b0, 6'd0);
      trig4[1] = 1'b1;
      wait_n(3);
      chk("R6 low pin works", req4, vec4, 1'b1, 6'd5);
      ack4 = 1'b1;
      @(negedge clk);
      ack4 = 1'b0;
      evt4 = 1'b1;
      @(negedge clk);
      evt4 = 1'b0;
      chk("R6 event vector", req4, vec4, 1'b1, 6'd32);
      ack4 = 1'b1;
      @(negedge clk);
      ack4 = 1'b0;
      chk("R6 idle", req4, vec4, 1'b0, 6'd0);
   endtask

   initial begin
      t_reset();
      t_fall_low();
      t_rise_low();
      t_high_group();
      t_event();
      t_priority();
      t_hold();
      t_ack_idle();
      t_absorb();
      t_small();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule